// File: doc/BRIEF.md
# Posted Write Cross-Domain Register Bridge

This block sits between a fast CPU-clock register port and a set of registers that must live in a slow, always-on clock domain (around 32 kHz). A CPU write to one of those registers is posted: the bridge takes the value at once, holds it in a one-entry slot for that register and carries it across the clock boundary with a toggle handshake. The CPU can continue working while the slow side applies the value.

For each slow register, the CPU sees a visibility bit. The bit is low while a posted write to that register is still in flight. It goes high once the slow domain has taken the value and the acknowledge has come back. A write aimed at a register whose slot is still busy is thrown away and raises a sticky error flag.

Three sticky flags live in the CPU domain: one for dispatch, one for completion and one for rejection. Each is cleared by writing a one to it, and clearing is immediate. An interrupt request goes out when any flag is set and its matching enable bit is also set.

Top module: `pwb_bridge`

## Requirements
- R1: After reset, the status word (address 0) reads every visibility bit (bit 8+i for slow register i) as 1 and flag bits 2:0 as 0. The control word (address 1), every slow register value and the interrupt output are all 0.
- R2: A write to slow register i (address 2+i) whose visibility bit is 1 is accepted. It clears that visibility bit on the next clock and leaves the visibility bits of the other registers unchanged.
- R3: An accepted value appears on the slow-domain output before the visibility bit returns to 1. Reads of address 2+i return the old value while the bit is 0 and the new value once it is 1. A slow register does not change unless a write to it has been accepted.
- R4: A write to slow register i while its visibility bit is 0 is discarded. The slow register keeps the earlier value, and the error flag (status bit 2) is 1 on the next clock.
- R5: The error flag stays 1 through further rejected writes and only returns to 0 after a status write with bit 2 set.
- R6: The dispatch flag (status bit 0) is set when the slow domain captures a posted value. It is already 1 when the visibility bit returns to 1.
- R7: The completion flag (status bit 1) is set each time a posted write becomes visible, including when it is already 1.
- R8: A status write clears, on the next clock, exactly the flags at whose position it carries a 1. Zeros leave flags alone, and the visibility bits are not writable.
- R9: The interrupt output is 1 exactly when some flag bit k (k=0..2) is set together with control bit k. With all enables at 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| sclk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_valid | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW | Write address: 0 status, 1 control, 2+i slow register i |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address, same map |
| rd_data | output | DW | Read data, combinational from rd_addr |
| slow_q | output | NREG*DW | Slow-domain register values, register i at bits i*DW upward |
| irq | output | 1 | Combined interrupt request |

## Verification
The block has both fixed and variable latencies, and the checks are timed to match each kind.

Fixed, one clock after the write strobe and sampled at the following falling edge:
- the drop of a visibility bit,
- the error flag,
- every write-one-to-clear effect,
- control writes.

The interrupt output follows the flags combinationally in the same cycle.

Variable: completion depends on the clock ratio. It takes about two to four slow cycles plus three CPU cycles. The bench therefore polls the visibility bit within a bounded window instead of expecting a fixed cycle. Once the bit is back, it checks that the dispatch and completion flags are set and that the read value matches. A scoreboard pairs every change on the slow outputs with the value queued when the write was posted.

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = $clog2(NREG + 2)
) (
  input  logic               clk,
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] slow_q,
  output logic               irq
);

  logic [NREG-1:0][DW-1:0] hold, sreg, vis;
  logic [NREG-1:0] busy, req_t, c1, c2, c3, d1, d2, d3;
  logic [NREG-1:0] r1, r2, r3, cap_t, done_t, apply;
  logic [NREG-1:0] hit, disp_ev, done_ev;
  logic [2:0] flags, ctl, clr, set;
  logic [DW-1:0] stat;

  always_comb
    for (int i = 0; i < NREG; i++)
      hit[i] = wr_valid && (wr_addr == AW'(i + 2));

  assign disp_ev = c2 ^ c3;
  assign done_ev = d2 ^ d3;
  assign clr = (wr_valid && wr_addr == '0) ? wr_data[2:0] : 3'b000;
  assign set = {|(hit & busy), |done_ev, |disp_ev};
  assign irq = |(flags & ctl);
  assign slow_q = sreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= '0; req_t <= '0; hold <= '0; vis <= '0;
      c1 <= '0; c2 <= '0; c3 <= '0;
      d1 <= '0; d2 <= '0; d3 <= '0;
    end else begin
      c1 <= cap_t;  c2 <= c1; c3 <= c2;
      d1 <= done_t; d2 <= d1; d3 <= d2;
      for (int i = 0; i < NREG; i++) begin
        if (hit[i] && !busy[i]) begin
          busy[i]  <= 1'b1;
          req_t[i] <= ~req_t[i];
          hold[i]  <= wr_data;
        end else if (done_ev[i]) begin
          busy[i] <= 1'b0;
          vis[i]  <= sreg[i];
        end
      end
    end

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) begin
      r1 <= '0; r2 <= '0; r3 <= '0;
      cap_t <= '0; done_t <= '0; apply <= '0; sreg <= '0;
    end else begin
      r1 <= req_t; r2 <= r1;
      for (int i = 0; i < NREG; i++) begin
        if (r2[i] != r3[i]) begin
          r3[i]    <= r2[i];
          cap_t[i] <= ~cap_t[i];
          apply[i] <= 1'b1;
        end else if (apply[i]) begin
          sreg[i]   <= hold[i];
          done_t[i] <= ~done_t[i];
          apply[i]  <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0;
      ctl   <= '0;
    end else begin
      flags <= (flags & ~clr) | set;
      if (wr_valid && wr_addr == AW'(1)) ctl <= wr_data[2:0];
    end

  always_comb begin
    stat = '0;
    stat[2:0] = flags;
    stat[8 +: NREG] = ~busy;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = stat;
    else if (rd_addr == AW'(1)) rd_data = DW'(ctl);
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i + 2)) rd_data = vis[i];
  end

endmodule

// File: rtl/pwb_bridge_chk.sv
module pwb_bridge_chk #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic [NREG*DW-1:0] slow_q,
  input logic               irq,
  input logic [NREG-1:0]    busy,
  input logic [2:0]         flags,
  input logic [2:0]         ctl
);

  logic stat_wr;
  assign stat_wr = wr_valid && wr_addr == '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic wr_hit;
    assign wr_hit = wr_valid && wr_addr == AW'(i + 2);

    AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !busy[i]) |=> busy[i]); // R2

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[i] && !wr_hit) |=> $stable(slow_q[i*DW +: DW])); // R3

    AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && busy[i]) |=> flags[2]); // R4
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !(stat_wr && wr_data[2])) |=> flags[2]); // R5

  AST_DISP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(stat_wr && wr_data[0])) |=> flags[0]); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 3'b000) |-> !irq); // R9

endmodule

bind pwb_bridge pwb_bridge_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .slow_q(slow_q), .irq(irq),
  .busy(busy), .flags(flags), .ctl(ctl)
);

// File: tb/tb_pwb_bridge.sv
module tb_pwb_bridge;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int AW   = 3;

  logic clk = 0, sclk = 0, rst_n = 0;
  logic wr_valid = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NREG*DW-1:0] slow_q;
  logic irq;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] sbq [NREG][$];
  logic [NREG*DW-1:0] last_q = '0;

  pwb_bridge #(.NREG(NREG), .DW(DW), .AW(AW)) dut (
    .clk(clk), .sclk(sclk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .slow_q(slow_q), .irq(irq)
  );

  always #4 clk = ~clk;
  initial begin #3; forever #40 sclk = ~sclk; end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic post(input int i, input logic [DW-1:0] d);
    sbq[i].push_back(d);
    wr(i + 2, d);
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic wait_vis(input int i);
    logic [DW-1:0] s;
    for (int n = 0; n < 300; n++) begin
      rd(0, s);
      if (s[8 + i]) return;
      @(negedge clk);
    end
    check("R3 completion timeout", 16'h0, 16'h1);
  endtask

  // scoreboard monitor: every change on a slow output must match the queued value
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        if (slow_q[i*DW +: DW] !== last_q[i*DW +: DW]) begin
          if (sbq[i].size() == 0) check("R3 unexpected slow update", slow_q[i*DW +: DW], last_q[i*DW +: DW]);
          else check("R3 slow value", slow_q[i*DW +: DW], sbq[i].pop_front());
        end
      end
    end
    last_q = slow_q;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); check("R1 status", v, 16'h0F00);
    rd(1, v); check("R1 control", v, 16'h0000);
    check("R1 irq", DW'(irq), 16'h0);
    check("R1 slow regs", DW'(|slow_q), 16'h0);

    // R2 / R3 single post
    post(0, 16'h1234);
    rd(0, v); check("R2 sync bit drops", v & 16'h0F00, 16'h0E00);
    rd(2, v); check("R3 old value while pending", v, 16'h0000);
    wait_vis(0);
    check("R3 slow output updated", slow_q[0 +: DW], 16'h1234);
    rd(2, v); check("R3 new value visible", v, 16'h1234);
    rd(0, v); check("R6 R7 dispatch and completion flags", v, 16'h0F03);

    // R8 write-one-to-clear
    wr(0, 16'h0001);
    rd(0, v); check("R8 clear dispatch only", v, 16'h0F02);
    wr(0, 16'h0000);
    rd(0, v); check("R8 zero write no effect", v, 16'h0F02);
    wr(0, 16'h0F00);
    rd(0, v); check("R8 sync bits read-only", v, 16'h0F02);
    wr(0, 16'h0002);
    rd(0, v); check("R8 clear completion", v, 16'h0F00);

    // R4 reject overlapping write
    post(1, 16'hAAAA);
    wr(3, 16'h5555);
    rd(0, v); check("R4 error flag set", v & 16'h0004, 16'h0004);
    wait_vis(1);
    rd(3, v); check("R4 rejected data discarded", v, 16'hAAAA);

    // R5 sticky error
    post(1, 16'h1111);
    wr(3, 16'h2222);
    rd(0, v); check("R5 error still set", v & 16'h0004, 16'h0004);
    wr(0, 16'h0004);
    rd(0, v); check("R5 error cleared", v & 16'h0004, 16'h0000);
    wait_vis(1);
    rd(3, v); check("R5 first value kept", v, 16'h1111);

    // R7 completion flag re-sets
    rd(0, v); check("R7 flag set before", v & 16'h0002, 16'h0002);
    post(2, 16'hBEEF);
    wait_vis(2);
    rd(0, v); check("R7 still set", v & 16'h0002, 16'h0002);
    wr(0, 16'h0002);
    rd(0, v); check("R7 cleared", v & 16'h0002, 16'h0000);
    post(3, 16'hC0DE);
    wait_vis(3);
    rd(0, v); check("R7 set again", v & 16'h0002, 16'h0002);

    // R2 concurrent posts to different registers
    post(0, 16'h0F0F);
    post(2, 16'h7777);
    rd(0, v); check("R2 two pending", v & 16'h0F00, 16'h0A00);
    wait_vis(0);
    wait_vis(2);
    rd(2, v); check("R2 reg0 value", v, 16'h0F0F);
    rd(4, v); check("R2 reg2 value", v, 16'h7777);

    // R9 interrupt gating
    wr(0, 16'h0007);
    wr(1, 16'h0000);
    post(3, 16'h4321);
    wait_vis(3);
    check("R9 masked irq", DW'(irq), 16'h0);
    wr(1, 16'h0001);
    check("R9 dispatch enabled", DW'(irq), 16'h1);
    wr(0, 16'h0001);
    check("R9 flag cleared", DW'(irq), 16'h0);
    wr(1, 16'h0002);
    check("R9 completion enabled", DW'(irq), 16'h1);

    repeat (4) @(negedge clk);
    for (int i = 0; i < NREG; i++)
      check("R3 scoreboard drained", DW'(sbq[i].size()), 16'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule